// File: doc/BRIEF.md
# CPU-Cycle Interrupt Down-Counter

This block is a 16-bit countdown timer that raises an interrupt request after a programmed number of CPU cycles. Software reaches it through three write-only register ports: a control port, a low-byte port and a high-byte port. A separate address decoder turns bus writes into the three strobes. While counting is enabled, each asserted CPU-cycle tick lowers the count by one. The request becomes pending on the tick that brings the count to zero.

Each write carries a load-mode flag. In direct mode, byte writes change the live counter. In latched mode, byte writes go into a 16-bit reload latch, and a control write then copies the latch into the counter. Every control write acknowledges any pending request and sets the enable. If counting is enabled and the resulting count is zero, the same write raises the request at once. Because the mode is chosen per write, one instance can serve software written for either loading style.

Top module: `cpu_cycle_irq_timer`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), `irq_pending` is 0, counting is disabled, and both the counter and the reload latch hold 0.
- R2: While enabled, the counter drops by one on every clock edge that has `cpu_tick` high. After a load of N > 0 and an enable, `irq_pending` rises on exactly the N-th tick and not before.
- R3: The counter keeps its value while counting is disabled, and on clocks without `cpu_tick`.
- R4: A clock edge with `wr_ctrl` high clears a pending request and sets the enable to `wr_data[0]` (1 = count).
- R5: A control write with `latch_mode` = 1 copies the 16-bit reload latch into the counter.
- R6: A control write with `latch_mode` = 0 leaves the counter value unchanged.
- R7: With `latch_mode` = 0, a `wr_lo` write replaces counter bits 7:0 and a `wr_hi` write replaces counter bits 15:8. The other byte is kept. Such a write takes the place of a decrement on the same clock.
- R8: With `latch_mode` = 1, a `wr_lo` or `wr_hi` write replaces the matching byte of the reload latch and leaves the running counter untouched.
- R9: A control write that enables counting when the resulting count is zero makes `irq_pending` high right after that clock edge.
- R10: Once set, `irq_pending` stays high through ticks and byte writes until the next control write.
- R11: The counter stops at zero and never wraps to 0xFFFF.
- R12: When a control write and a tick fall on the same clock, the control write takes effect and the counter is not decremented on that clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_tick | input | 1 | One-clock pulse per CPU cycle |
| wr_ctrl | input | 1 | Write strobe for the control port |
| wr_lo | input | 1 | Write strobe for the low-byte port |
| wr_hi | input | 1 | Write strobe for the high-byte port |
| latch_mode | input | 1 | Load mode for this write: 0 = direct, 1 = latched |
| wr_data | input | 8 | Write data. For the control port, bit 0 is the enable |
| irq_pending | output | 1 | Level interrupt request |

## Verification
The countdown is exercised with a table of load values: one, two, three, a byte-boundary value (256), and values with both bytes nonzero. Each value is loaded in both modes. These cases separate an off-by-one in the zero detection, a high byte that is dropped or mixed up with the low byte, and a mode whose reload path is missing. Directed sequences then stop the tick stream, disable counting, overwrite single bytes, and write the latch while the counter runs. In each case the only visible result is the tick on which the request rises, so any wrong counter contents show up as an early or late request. Further directed cases cover these corners:
- an enable with a zero count, which must fire at once;
- ticks continuing past zero, which must not wrap the counter;
- a control write colliding with a tick, which must win that clock.

// File: rtl/cpu_cycle_irq_pkg.sv
// Package: shared constants and types for the CPU-cycle interrupt timer.
// Assumes byte-wide register ports and a counter two bytes wide.
package cpu_cycle_irq_pkg;

    // Width of one register port write.
    localparam int unsigned IRQ_BYTE_W = 8;

    // Load-mode encoding carried with every register write.
    typedef enum logic {
        LOAD_DIRECT  = 1'b0,
        LOAD_LATCHED = 1'b1
    } load_mode_e;

endpackage

// File: rtl/irq_reload_latch.sv
// Module: reload latch for latched-mode loading.
// Byte writes marked latched replace one half of the latch. The whole
// latch is offered to the counter as its reload value.
// Assumes the write strobes last one clock each.
module irq_reload_latch
    import cpu_cycle_irq_pkg::*;
#(
    parameter int unsigned BYTE_W = IRQ_BYTE_W,
    localparam int unsigned CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  load_mode_e        mode,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  reload_val
);

    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;
    logic              lo_we;
    logic              hi_we;

    // Decide which latch byte a latched-mode write targets.
    always_comb begin
        lo_we = wr_lo && (mode == LOAD_LATCHED);
        hi_we = wr_hi && (mode == LOAD_LATCHED);
    end

    // Store latched-mode byte writes; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (lo_we) lo_q <= wr_data;
            if (hi_we) hi_q <= wr_data;
        end
    end

    // Present the assembled reload value.
    assign reload_val = {hi_q, lo_q};

    // R8
    latch_lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_we |=> reload_val[BYTE_W-1:0] == $past(wr_data));

    // R8
    latch_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_we && !hi_we) |=> reload_val[CNT_W-1:BYTE_W] == $past(reload_val[CNT_W-1:BYTE_W]));

endmodule

// File: rtl/irq_down_counter.sv
// Module: live down-counter and enable bit.
// On each clock, the first matching action below is taken:
//   1. control write: set the enable, reload from the latch in latched mode;
//   2. direct byte write: replace that counter byte;
//   3. enabled tick with a nonzero count: decrement.
// Outputs two one-clock events. arm_fire means a control write has just
// enabled counting on a zero count. expire means a tick is taking the
// count from one to zero.
// Assumes cpu_tick is a single-clock pulse per CPU cycle.
module irq_down_counter
    import cpu_cycle_irq_pkg::*;
#(
    parameter int unsigned BYTE_W = IRQ_BYTE_W,
    localparam int unsigned CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_ctrl,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  load_mode_e        mode,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  reload_val,
    output logic              arm_fire,
    output logic              expire
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             en_q;
    logic             dir_lo;
    logic             dir_hi;
    logic [CNT_W-1:0] ctrl_val;
    logic             dec_ok;

    // Work out the direct byte writes and the count left after a control write.
    always_comb begin
        dir_lo   = wr_lo && (mode == LOAD_DIRECT) && !wr_ctrl;
        dir_hi   = wr_hi && (mode == LOAD_DIRECT) && !wr_ctrl;
        ctrl_val = (mode == LOAD_LATCHED) ? reload_val : cnt_q;
        dec_ok   = en_q && tick && (cnt_q != '0) && !wr_ctrl && !dir_lo && !dir_hi;
    end

    // Update the counter and the enable in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else if (wr_ctrl) begin
            en_q  <= wr_data[0];
            cnt_q <= ctrl_val;
        end else if (dir_lo || dir_hi) begin
            if (dir_lo) cnt_q[BYTE_W-1:0]     <= wr_data;
            if (dir_hi) cnt_q[CNT_W-1:BYTE_W] <= wr_data;
        end else if (dec_ok) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    // Raise the two request events.
    always_comb begin
        arm_fire = wr_ctrl && wr_data[0] && (ctrl_val == '0);
        expire   = dec_ok && (cnt_q == CNT_ONE);
    end

    // R11
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !wr_ctrl && !dir_lo && !dir_hi) |=> cnt_q == '0);

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!en_q || !tick) && !wr_ctrl && !dir_lo && !dir_hi) |=> $stable(cnt_q));

    // R2
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && tick && cnt_q != '0 && !wr_ctrl && !wr_lo && !wr_hi) |=> cnt_q == $past(cnt_q) - CNT_ONE);

    // R6
    direct_ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && mode == LOAD_DIRECT) |=> $stable(cnt_q));

    // R12
    ctrl_beats_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && tick && mode == LOAD_DIRECT) |=> cnt_q == $past(cnt_q));

endmodule

// File: rtl/irq_pending_flag.sv
// Module: level interrupt request flag.
// A control write always clears the flag, unless that same write enables
// counting on a zero count, in which case it sets the flag. A countdown
// expiry sets the flag. Nothing else changes it.
// Assumes the events come from irq_down_counter for the same clock.
module irq_pending_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctrl,
    input  logic arm_fire,
    input  logic expire,
    output logic pending
);

    // Hold, acknowledge or raise the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (wr_ctrl) begin
            pending <= arm_fire;
        end else if (expire) begin
            pending <= 1'b1;
        end
    end

    // R10
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !wr_ctrl) |=> pending);

    // R4
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !arm_fire) |=> !pending);

    // R2
    expire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pending);

    // R9
    arm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_fire |=> pending);

endmodule

// File: rtl/cpu_cycle_irq_timer.sv
// Module: CPU-cycle interrupt down-counter (top).
// Joins the reload latch, the down-counter and the request flag. Address
// decoding is done outside this block, which sees one strobe per port.
// Assumes at most one of the strobes is used per access; a control write
// that coincides with a direct byte write takes priority over it.
module cpu_cycle_irq_timer
    import cpu_cycle_irq_pkg::*;
#(
    parameter int unsigned BYTE_W = IRQ_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_tick,
    input  logic              wr_ctrl,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              latch_mode,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              irq_pending
);

    localparam int unsigned CNT_W = 2 * BYTE_W;

    load_mode_e       mode;
    logic [CNT_W-1:0] reload_val;
    logic             arm_fire;
    logic             expire;

    // Map the raw mode pin onto the load-mode type.
    always_comb mode = load_mode_e'(latch_mode);

    irq_reload_latch #(.BYTE_W(BYTE_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .mode       (mode),
        .wr_data    (wr_data),
        .reload_val (reload_val)
    );

    irq_down_counter #(.BYTE_W(BYTE_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (cpu_tick),
        .wr_ctrl    (wr_ctrl),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .mode       (mode),
        .wr_data    (wr_data),
        .reload_val (reload_val),
        .arm_fire   (arm_fire),
        .expire     (expire)
    );

    irq_pending_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .arm_fire(arm_fire),
        .expire  (expire),
        .pending (irq_pending)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !irq_pending);

    // R4
    port_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wr_data[0]) |=> !irq_pending);

endmodule

// File: tb/cpu_cycle_irq_timer_test.sv
module cpu_cycle_irq_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_tick = 1'b0;
    logic       wr_ctrl = 1'b0;
    logic       wr_lo = 1'b0;
    logic       wr_hi = 1'b0;
    logic       latch_mode = 1'b0;
    logic [7:0] wr_data = '0;
    logic       irq_pending;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    cpu_cycle_irq_timer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_tick   (cpu_tick),
        .wr_ctrl    (wr_ctrl),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .latch_mode (latch_mode),
        .wr_data    (wr_data),
        .irq_pending(irq_pending)
    );

    // Vector: {latched, load value}. The request is expected on tick number = value.
    localparam int NVEC = 8;
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 16'd3},   {1'b1, 16'd3},   {1'b0, 16'd1},   {1'b1, 16'd2},
        {1'b0, 16'd256}, {1'b1, 16'h0105}, {1'b0, 16'h0201}, {1'b1, 16'd1}
    };

    task automatic chk(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: irq_pending=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One register write. All inputs change at the falling edge.
    task automatic wr(input int port, input logic lat, input logic [7:0] d, input logic tk = 1'b0);
        latch_mode = lat;
        wr_data    = d;
        cpu_tick   = tk;
        wr_ctrl    = (port == 0);
        wr_lo      = (port == 1);
        wr_hi      = (port == 2);
        @(negedge clk);
        wr_ctrl = 1'b0; wr_lo = 1'b0; wr_hi = 1'b0; cpu_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            cpu_tick = 1'b1;
            @(negedge clk);
        end
        cpu_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load(input logic lat, input logic [15:0] v);
        wr(1, lat, v[7:0]);
        wr(2, lat, v[15:8]);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: request low during and after reset
        chk(irq_pending, 1'b0, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq_pending, 1'b0, "R1 after reset");
        // R1/R9: counter is zero after reset, so a direct enable fires at once
        wr(0, 1'b0, 8'h01);
        chk(irq_pending, 1'b1, "R1 R9 zero counter enable");
        wr(0, 1'b0, 8'h00);
        chk(irq_pending, 1'b0, "R4 ack");

        // Table walk. R2 exact tick count, R5 latched reload, R7 byte placement
        for (int k = 0; k < NVEC; k++) begin
            load(VEC[k][16], VEC[k][15:0]);
            wr(0, VEC[k][16], 8'h01);
            chk(irq_pending, 1'b0, "R2 R5 no request at enable");
            ticks(int'(VEC[k][15:0]) - 1);
            chk(irq_pending, 1'b0, "R2 not before last tick");
            ticks(1);
            chk(irq_pending, 1'b1, "R2 request on last tick");
            wr(0, 1'b0, 8'h00);
            chk(irq_pending, 1'b0, "R4 ack after vector");
        end

        // R3: no decrement without tick
        load(1'b0, 16'd3);
        wr(0, 1'b0, 8'h01);
        idle(10);
        ticks(2);
        chk(irq_pending, 1'b0, "R3 no tick no decrement");
        ticks(1);
        chk(irq_pending, 1'b1, "R3 resumes");

        // R3/R6: disabled holds; direct enable keeps count
        load(1'b0, 16'd2);
        wr(0, 1'b0, 8'h00);
        chk(irq_pending, 1'b0, "R4 disable acks");
        ticks(5);
        chk(irq_pending, 1'b0, "R3 disabled quiet");
        wr(0, 1'b0, 8'h01);
        ticks(1);
        chk(irq_pending, 1'b0, "R6 count kept at 2");
        ticks(1);
        chk(irq_pending, 1'b1, "R6 fires after 2");

        // R10: sticky through ticks and byte writes
        ticks(4);
        wr(1, 1'b1, 8'h09);
        wr(2, 1'b0, 8'h00);
        chk(irq_pending, 1'b1, "R10 sticky");
        // R11: counter stayed at zero, re-enable fires immediately
        wr(0, 1'b0, 8'h01);
        chk(irq_pending, 1'b1, "R11 no wrap");
        wr(0, 1'b0, 8'h00);

        // R7: single byte replacement of the live counter
        load(1'b0, 16'h0002);
        wr(1, 1'b0, 8'h04);          // counter 0x0004
        wr(2, 1'b0, 8'h01);          // counter 0x0104 = 260
        wr(0, 1'b0, 8'h01);
        ticks(259);
        chk(irq_pending, 1'b0, "R7 byte merge not early");
        ticks(1);
        chk(irq_pending, 1'b1, "R7 byte merge 260");
        wr(0, 1'b0, 8'h00);

        // R7: a direct byte write wins over a tick on the same clock
        load(1'b0, 16'd5);
        wr(0, 1'b0, 8'h01);
        ticks(2);                    // count 3
        wr(1, 1'b0, 8'h02, 1'b1);    // count 2, no decrement
        ticks(1);
        chk(irq_pending, 1'b0, "R7 byte write beats tick");
        ticks(1);
        chk(irq_pending, 1'b1, "R7 fires after rewrite");
        wr(0, 1'b0, 8'h00);

        // R8: latched writes leave the running counter alone
        load(1'b0, 16'd2);
        wr(0, 1'b0, 8'h01);
        wr(1, 1'b1, 8'h07);
        wr(2, 1'b1, 8'h00);
        ticks(1);
        chk(irq_pending, 1'b0, "R8 counter untouched early");
        ticks(1);
        chk(irq_pending, 1'b1, "R8 counter untouched");
        // R5: latch holds 7, latched enable reloads it
        wr(0, 1'b1, 8'h01);
        chk(irq_pending, 1'b0, "R5 reload ack");
        ticks(6);
        chk(irq_pending, 1'b0, "R5 latch 7 not early");
        ticks(1);
        chk(irq_pending, 1'b1, "R5 latch 7");
        wr(0, 1'b0, 8'h00);

        // R12: control write with tick on the same clock
        load(1'b0, 16'd3);
        wr(0, 1'b0, 8'h01);
        ticks(1);                    // count 2
        wr(0, 1'b0, 8'h01, 1'b1);    // count stays 2
        ticks(1);
        chk(irq_pending, 1'b0, "R12 ctrl beats tick");
        ticks(1);
        chk(irq_pending, 1'b1, "R12 fires after 2");
        wr(0, 1'b0, 8'h00);

        // R9: latched enable with zero latch fires immediately
        load(1'b1, 16'd0);
        wr(0, 1'b1, 8'h01);
        chk(irq_pending, 1'b1, "R9 latched zero");

        // R1: reset mid-run clears request and latch
        load(1'b1, 16'd9);
        rst_n = 1'b0;
        @(negedge clk);
        chk(irq_pending, 1'b0, "R1 mid-run reset");
        rst_n = 1'b1;
        wr(0, 1'b1, 8'h01);
        chk(irq_pending, 1'b1, "R1 latch cleared by reset");

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule